// File: doc/BRIEF.md
# Status Register Write Protection Unit

This block holds the protection state of a serial nonvolatile byte memory: a write-enable latch, a protect-enable flag that arms the hardware write-protect pin, and a two-bit block-protect code that locks an upper fraction of the address space. A command decoder upstream presents one-cycle strobes for "enable writes", "disable writes", a status-register write with its data byte, and a memory byte commit with its address. The unit answers each request in the same cycle with a grant (`sr_wr_ok` or `mem_wr_ok`) and presents the packed status byte for status reads.

Chip-select framing reaches the block as two strobes: `frame_start` at the select falling edge and `frame_end` at its rising edge. The write-protect pin is captured only at `frame_start`, so a pin change during a frame has no effect until the next one. A frame that had at least one write granted clears the write-enable latch when it ends. The protection state is held in ordinary flops.

Top module: `status_guard`

## Requirements
- R1: After reset the status byte reads 8'h40 (with `wake_busy` low), both grants are low, and the captured pin value is high.
- R2: Status byte layout: bit7 protect-enable, bit6 constant 1, bits 5:4 constant 0, bits 3:2 block-protect code, bit1 write-enable latch, bit0 equal to `wake_busy`.
- R3: `wen_set` sets the write-enable latch on the next edge. `wen_clr` clears it, and `wen_clr` wins when both arrive together.
- R4: A granted status write loads data bit7 into protect-enable and data bits 3:2 into the block-protect code. Data bits 6:4, 1 and 0 are ignored, so it cannot alter the latch or the constant bits.
- R5: `sr_wr_ok` is high exactly when `sr_wr_req` is high, the latch is set, and it is not the case that protect-enable is 1 while the captured pin is low. With protect-enable 0 the pin has no effect.
- R6: `wp_pin_n` is captured only on cycles with `frame_start`. Changing it at any other time does not change grants until the next `frame_start`.
- R7: Block-protect code 00 locks nothing, 01 locks addresses 30000h to 3FFFFh, 10 locks 20000h to 3FFFFh, and 11 locks the whole 18-bit space.
- R8: `mem_wr_ok` is high exactly when `mem_wr_req` is high, the latch is set, and the address is outside the locked range. Several bytes can be granted within one frame.
- R9: A `frame_end` clears the latch if a write (status or memory) was granted in that frame, including in the same cycle. A frame with no granted write leaves the latch unchanged.
- R10: A denied status write leaves protect-enable and the block-protect code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Strobe at chip-select assertion |
| frame_end | input | 1 | Strobe at chip-select release |
| wen_set | input | 1 | Enable-writes command strobe |
| wen_clr | input | 1 | Disable-writes command strobe |
| sr_wr_req | input | 1 | Status-register write request |
| sr_wr_data | input | 8 | Data byte for the status write |
| mem_wr_req | input | 1 | Memory byte commit request |
| mem_wr_addr | input | 18 | Address of the byte to commit |
| wp_pin_n | input | 1 | Active-low hardware write-protect pin |
| wake_busy | input | 1 | Wake-up in progress; reported in bit0 |
| status_byte | output | 8 | Packed status byte for reads |
| sr_wr_ok | output | 1 | Status write granted this cycle |
| mem_wr_ok | output | 1 | Memory write granted this cycle |

## Verification
Memory commits are issued at addresses on both sides of each block-protect boundary (1FFFFh/20000h, 2FFFFh/30000h, 0 and 3FFFFh) under every protect code. This separates an off-by-one range decode from a wrong code mapping. Status writes are attempted with the latch clear, with the pin low while protect-enable is on and off, and with the pin toggled in the middle of a frame. Together these separate the latch gate, the pin gate and the capture point of the pin. Frames that end with and without a granted write, and simultaneous enable and disable strobes, distinguish automatic latch clearing from plain command handling.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int SR_W       = 8;
  localparam int SR_PEN_BIT = 7;
  localparam int SR_ONE_BIT = 6;
  localparam int SR_BPH_BIT = 3;
  localparam int SR_BPL_BIT = 2;
  localparam int SR_WEL_BIT = 1;
  localparam int SR_BSY_BIT = 0;

  typedef struct packed {
    logic       pen;
    logic [1:0] bp;
  } prot_cfg_t;

  function automatic logic [SR_W-1:0] sr_pack(prot_cfg_t c, logic wel, logic busy);
    logic [SR_W-1:0] s;
    s = '0;
    s[SR_PEN_BIT] = c.pen;
    s[SR_ONE_BIT] = 1'b1;
    s[SR_BPH_BIT:SR_BPL_BIT] = c.bp;
    s[SR_WEL_BIT] = wel;
    s[SR_BSY_BIT] = busy;
    return s;
  endfunction

  function automatic logic sr_gate(logic wel, logic pen, logic pin_n);
    return wel && !(pen && !pin_n);
  endfunction
endpackage

// File: rtl/block_range.sv
module block_range #(
  parameter int AW = 18
) (
  input  logic [1:0]    bp,
  input  logic [AW-1:0] addr,
  output logic          locked
);
  localparam int TOP = AW - 1;

  function automatic logic in_lock(logic [1:0] code, logic [AW-1:0] a);
    case (code)
      2'b00:   return 1'b0;
      2'b01:   return a[TOP] & a[TOP-1];
      2'b10:   return a[TOP];
      default: return 1'b1;
    endcase
  endfunction

  assign locked = in_lock(bp, addr);
endmodule

// File: rtl/cfg_reg.sv
module cfg_reg
  import sgd_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            pin_n,
  input  logic            wr_en,
  input  logic [SR_W-1:0] wr_data,
  output prot_cfg_t       cfg,
  output logic            pin_lat
);
  logic unused_bits;
  assign unused_bits = ^{wr_data[6:4], wr_data[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg     <= '0;
      pin_lat <= 1'b1;
    end else begin
      if (frame_start) pin_lat <= pin_n;
      if (wr_en) cfg <= '{pen: wr_data[SR_PEN_BIT], bp: wr_data[SR_BPH_BIT:SR_BPL_BIT]};
    end
  end

  // R6
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(pin_lat));
  // R10
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));
endmodule

// File: rtl/wel_ctrl.sv
module wel_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic accept,
  input  logic frame_start,
  input  logic frame_end,
  output logic wel
);
  logic pend_q;
  logic auto_clr;

  assign auto_clr = frame_end && (pend_q || accept);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wel    <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (clr || auto_clr) wel <= 1'b0;
      else if (set)        wel <= 1'b1;
      if (frame_start || frame_end) pend_q <= 1'b0;
      else if (accept)              pend_q <= 1'b1;
    end
  end

  // R3
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set && !clr && !frame_end |=> wel);
  // R3
  wel_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !wel);
  // R9
  wel_auto_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && (pend_q || accept) |=> !wel);
  // R9
  wel_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end && !pend_q && !accept && !clr && !set |=> $stable(wel));
endmodule

// File: rtl/status_guard.sv
module status_guard
  import sgd_pkg::*;
#(
  parameter int AW = 18
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_start,
  input  logic            frame_end,
  input  logic            wen_set,
  input  logic            wen_clr,
  input  logic            sr_wr_req,
  input  logic [SR_W-1:0] sr_wr_data,
  input  logic            mem_wr_req,
  input  logic [AW-1:0]   mem_wr_addr,
  input  logic            wp_pin_n,
  input  logic            wake_busy,
  output logic [SR_W-1:0] status_byte,
  output logic            sr_wr_ok,
  output logic            mem_wr_ok
);
  prot_cfg_t cfg;
  logic      pin_lat;
  logic      wel;
  logic      addr_locked;
  logic      accept;

  assign sr_wr_ok    = sr_wr_req && sr_gate(wel, cfg.pen, pin_lat);
  assign mem_wr_ok   = mem_wr_req && wel && !addr_locked;
  assign accept      = sr_wr_ok || mem_wr_ok;
  assign status_byte = sr_pack(cfg, wel, wake_busy);

  cfg_reg u_cfg (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .pin_n(wp_pin_n),
    .wr_en(sr_wr_ok), .wr_data(sr_wr_data), .cfg(cfg), .pin_lat(pin_lat)
  );

  wel_ctrl u_wel (
    .clk(clk), .rst_n(rst_n), .set(wen_set), .clr(wen_clr), .accept(accept),
    .frame_start(frame_start), .frame_end(frame_end), .wel(wel)
  );

  block_range #(.AW(AW)) u_range (
    .bp(cfg.bp), .addr(mem_wr_addr), .locked(addr_locked)
  );

  // R8
  mem_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_ok |-> status_byte[SR_WEL_BIT]);
  // R5
  pin_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.pen && !pin_lat |-> !sr_wr_ok);
  // R7
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[SR_BPH_BIT:SR_BPL_BIT] == 2'b11 |-> !mem_wr_ok);
  // R4
  sr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_ok |=> status_byte[SR_PEN_BIT] == $past(sr_wr_data[SR_PEN_BIT]) &&
                 status_byte[SR_BPH_BIT:SR_BPL_BIT] == $past(sr_wr_data[SR_BPH_BIT:SR_BPL_BIT]));
endmodule

// File: tb/status_guard_tb.sv
`timescale 1ns/1ps
module status_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 0, frame_end = 0, wen_set = 0, wen_clr = 0;
  logic        sr_wr_req = 0, mem_wr_req = 0, wp_pin_n = 1, wake_busy = 0;
  logic [7:0]  sr_wr_data = 0;
  logic [17:0] mem_wr_addr = 0;
  logic [7:0]  status_byte;
  logic        sr_wr_ok, mem_wr_ok;

  int errors = 0;
  int checks = 0;

  // reference state
  bit       m_wel = 0, m_pen = 0, m_pin = 1, m_pend = 0;
  bit [1:0] m_bp = 0;

  always #10 clk = ~clk;

  status_guard dut_i (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .frame_end(frame_end),
    .wen_set(wen_set), .wen_clr(wen_clr), .sr_wr_req(sr_wr_req), .sr_wr_data(sr_wr_data),
    .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .wp_pin_n(wp_pin_n),
    .wake_busy(wake_busy), .status_byte(status_byte), .sr_wr_ok(sr_wr_ok), .mem_wr_ok(mem_wr_ok)
  );

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic step(string tag, bit fs, bit fe, bit st, bit cl, bit sq, logic [7:0] sd,
                      bit mq, logic [17:0] ma, bit wp, bit bz);
    int limit;
    bit e_sr, e_mem, acc;
    logic [7:0] e_st;
    frame_start = fs; frame_end = fe; wen_set = st; wen_clr = cl;
    sr_wr_req = sq; sr_wr_data = sd; mem_wr_req = mq; mem_wr_addr = ma;
    wp_pin_n = wp; wake_busy = bz;
    #2;
    case (m_bp)
      2'd0: limit = 262144;
      2'd1: limit = 'h30000;
      2'd2: limit = 'h20000;
      default: limit = 0;
    endcase
    e_st  = {m_pen, 1'b1, 2'b00, m_bp, m_wel, bz};
    e_sr  = sq && m_wel && !(m_pen && !m_pin);
    e_mem = mq && m_wel && (int'(ma) < limit);
    check(tag, "status", status_byte, e_st);
    check(tag, "sr_ok", sr_wr_ok, e_sr);
    check(tag, "mem_ok", mem_wr_ok, e_mem);
    acc = e_sr || e_mem;
    @(posedge clk);
    if (e_sr) begin m_pen = sd[7]; m_bp = sd[3:2]; end
    if (cl || (fe && (m_pend || acc))) m_wel = 0;
    else if (st) m_wel = 1;
    if (fs || fe) m_pend = 0; else if (acc) m_pend = 1;
    if (fs) m_pin = wp;
    @(negedge clk);
  endtask

  task automatic idle(string tag, bit wp);
    step(tag, 0,0,0,0, 0,8'h00, 0,18'h0, wp, 0);
  endtask

  task automatic enable(string tag, bit wp);
    step(tag, 1,0,0,0, 0,8'h00, 0,18'h0, wp, 0);
    step(tag, 0,0,1,0, 0,8'h00, 0,18'h0, wp, 0);
    step(tag, 0,1,0,0, 0,8'h00, 0,18'h0, wp, 0);
  endtask

  task automatic sr_frame(string tag, logic [7:0] d, bit wp_open, bit wp_mid);
    step(tag, 1,0,0,0, 0,8'h00, 0,18'h0, wp_open, 0);
    step(tag, 0,0,0,0, 1,d,     0,18'h0, wp_mid, 0);
    step(tag, 0,1,0,0, 0,8'h00, 0,18'h0, wp_mid, 0);
  endtask

  task automatic mem_probe(string tag, logic [17:0] a);
    step(tag, 0,0,0,0, 0,8'h00, 1,a, 1, 0);
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    idle("R1", 1);
    // R2 bit0 follows wake_busy
    step("R2", 0,0,0,0, 0,8'h00, 0,18'h0, 1, 1);
    // R10 write with latch clear is denied
    sr_frame("R10", 8'hFF, 1, 1);
    // R3 enable / disable / both
    enable("R3", 1);
    idle("R3", 1);
    step("R3", 0,0,0,1, 0,8'h00, 0,18'h0, 1, 0);
    step("R3", 0,0,1,1, 0,8'h00, 0,18'h0, 1, 0);
    idle("R3", 1);
    // R4 data bit1 and constant bits ignored; R9 latch clears at frame end
    enable("R4", 1);
    sr_frame("R4", 8'hBE, 1, 1);
    idle("R9", 1);
    // R8 whole space locked (code 11)
    enable("R8", 1);
    step("R8", 1,0,0,0, 0,8'h00, 0,18'h0, 1, 0);
    mem_probe("R8", 18'h00000);
    mem_probe("R8", 18'h3FFFF);
    step("R9", 0,1,0,0, 0,8'h00, 0,18'h0, 1, 0);
    idle("R9", 1);
    // R5 pin low with protect-enable on: denied, latch kept
    sr_frame("R5", 8'h84, 0, 0);
    idle("R9", 0);
    // R6 pin high at frame start, dropped mid-frame: granted
    sr_frame("R6", 8'h84, 1, 0);
    idle("R6", 0);
    // R7 code 01: boundary at 30000h, several bytes in one frame
    enable("R7", 1);
    step("R7", 1,0,0,0, 0,8'h00, 0,18'h0, 1, 0);
    mem_probe("R7", 18'h2FFFF);
    mem_probe("R7", 18'h30000);
    mem_probe("R7", 18'h3FFFF);
    mem_probe("R8", 18'h00000);
    step("R9", 0,1,0,0, 0,8'h00, 0,18'h0, 1, 0);
    mem_probe("R8", 18'h00000);
    // R5 protect-enable off: pin ignored; set code 10
    enable("R5", 1);
    sr_frame("R5", 8'h08, 1, 1);
    enable("R5", 0);
    sr_frame("R5", 8'h08, 0, 0);
    // R7 code 10: boundary at 20000h, grant in the frame-end cycle
    enable("R7", 1);
    step("R7", 1,0,0,0, 0,8'h00, 0,18'h0, 1, 0);
    mem_probe("R7", 18'h1FFFF);
    mem_probe("R7", 18'h20000);
    step("R9", 0,1,0,0, 0,8'h00, 1,18'h00010, 1, 0);
    idle("R9", 1);
    // R7 code 00: top address free
    enable("R7", 1);
    sr_frame("R7", 8'h00, 1, 1);
    enable("R7", 1);
    step("R7", 1,0,0,0, 0,8'h00, 0,18'h0, 1, 0);
    mem_probe("R7", 18'h3FFFF);
    step("R9", 0,1,0,0, 0,8'h00, 0,18'h0, 1, 0);
    idle("R1", 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule